// File: doc/BRIEF.md
# Interrupt-Aware Return Address Stack

This block keeps the return addresses of a small processor core in a four-entry hardware stack. Each entry is a 10-bit program counter value. A subroutine call saves the current program counter, and so does an interrupt that the block grants. A return, whether from a subroutine or from an interrupt service routine, removes the newest entry and presents it as the address to resume from.

The block owns the single latch that remembers an interrupt request until it can be served. A request is granted only when a stack level is free and no call or return uses the stack in the same cycle. While all four levels are taken, the request waits. The grant then comes in the first free cycle after a return has released a level.

A call is never refused. A call on a full stack still saves its address, and the oldest saved address is overwritten. The stack and its pointer are hidden from software. The core sees only the popped address, a full flag, the interrupt grant, and a one-cycle underflow pulse that marks a return on an empty stack.

Top module: `ret_stack`

## Requirements
- R1: After reset the stack holds no entries: `full_o` is low, `irq_ack_o` is low while no request is present, and the first return raises `udf_o`.
- R2: A cycle with `call_i` high saves `cur_pc_i`. Returns yield saved addresses newest first.
- R3: In a cycle with `ret_i` high on a non-empty stack, `ret_pc_o` equals the newest saved address, and that entry is then removed.
- R4: `irq_ack_o` is high in a cycle exactly when a request is present (`irq_i` now or latched earlier), fewer than 4 entries are held, and neither `call_i` nor `ret_i` is high. A granted cycle saves `cur_pc_i` like a call.
- R5: `full_o` is high exactly while 4 entries are held.
- R6: While `full_o` is high, `irq_ack_o` stays low and the request stays latched.
- R7: A request deferred by a full stack is granted in the next cycle after a return, provided that cycle has no call or return.
- R8: A call on a full stack saves `cur_pc_i` and discards the oldest entry. The stack stays at 4 entries.
- R9: When `call_i` and a request fall in the same cycle, the call is served and the request stays latched. It is granted in a later cycle when R4 allows.
- R10: A return on an empty stack raises `udf_o` for that cycle and leaves the stack empty. If `call_i` is also high, the call is still saved.
- R11: When `ret_i` and `call_i` are high together on a non-empty stack, `ret_pc_o` shows the newest entry, that entry is replaced by `cur_pc_i`, and the entry count does not change.
- R12: Each grant clears the latch: one request produces exactly one grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| call_i | input | 1 | Subroutine call: save `cur_pc_i` |
| irq_i | input | 1 | Enabled interrupt request (one-cycle pulse or level) |
| ret_i | input | 1 | Return or return-from-interrupt: remove the newest entry |
| cur_pc_i | input | 10 | Program counter to save |
| ret_pc_o | output | 10 | Newest saved address, used as the next PC when `ret_i` is high |
| full_o | output | 1 | All 4 levels are occupied |
| irq_ack_o | output | 1 | Interrupt granted this cycle (`cur_pc_i` is saved) |
| udf_o | output | 1 | Return on an empty stack this cycle |

## Verification
Two pairs of events can fall in the same cycle. A call can meet an interrupt request, and a return can meet a pending request on a full stack. The sweep provokes both from every occupancy level from 0 to 4, with and without a request already latched, and with every combination of call, request and return.

For every cycle, a shift-register model in the bench predicts the grant, the full flag, the underflow pulse and the popped address. The stack is then drained and each returned address is compared, so an entry lost or reordered by a collision shows up as a wrong address.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Stack operation chosen for one cycle
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stk_op_e;
endpackage

// File: rtl/rs_irq_gate.sv
module rs_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic call_i,
  input  logic ret_i,
  input  logic full_i,
  output logic ack_o
);
  logic pend_q, pend_d, pend_eff;

  always_comb begin
    pend_eff = pend_q | irq_i;
    // grant only when a level is free and the stack port is otherwise idle
    ack_o    = pend_eff & ~full_i & ~call_i & ~ret_i;
    pend_d   = pend_eff & ~ack_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/rs_ptr_ctrl.sv
module rs_ptr_ctrl
  import rs_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_idx_o,
  output logic [PW-1:0] rd_idx_o,
  output logic          full_o,
  output logic          udf_o
);
  stk_op_e       op;
  logic [PW-1:0] top_q, top_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          empty, upd_en;

  assign empty = (cnt_q == '0);

  // operation decode
  always_comb begin
    op = OP_IDLE;
    if (push_i && pop_i)  op = empty ? OP_PUSH : OP_SWAP;
    else if (push_i)      op = OP_PUSH;
    else if (pop_i)       op = empty ? OP_IDLE : OP_POP;
  end

  // next state
  always_comb begin
    top_d    = top_q;
    cnt_d    = cnt_q;
    wr_en_o  = 1'b0;
    wr_idx_o = top_q + PW'(1);
    unique case (op)
      OP_PUSH: begin
        top_d   = top_q + PW'(1);
        wr_en_o = 1'b1;
        // circular buffer: when full, the next slot is the oldest entry
        if (cnt_q != CW'(DEPTH)) cnt_d = cnt_q + CW'(1);
      end
      OP_POP: begin
        top_d = top_q - PW'(1);
        cnt_d = cnt_q - CW'(1);
      end
      OP_SWAP: begin
        wr_en_o  = 1'b1;
        wr_idx_o = top_q;
      end
      default: ;
    endcase
  end

  assign upd_en   = (op != OP_IDLE);
  assign rd_idx_o = top_q;
  assign full_o   = (cnt_q == CW'(DEPTH));
  assign udf_o    = pop_i & empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= PW'(DEPTH - 1);
      cnt_q <= '0;
    end else if (upd_en) begin
      top_q <= top_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rs_store.sv
module rs_store #(
  parameter  int DEPTH = 4,
  parameter  int PC_W  = 10,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            wr_en_i,
  input  logic [PW-1:0]   wr_idx_i,
  input  logic [PC_W-1:0] wr_data_i,
  input  logic [PW-1:0]   rd_idx_i,
  output logic [PC_W-1:0] rd_data_o
);
  logic [PC_W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic            hit;
    logic [PC_W-1:0] q;
    assign hit = wr_en_i && (wr_idx_i == PW'(g));
    // storage carries no reset; occupancy decides validity
    always_ff @(posedge clk) begin
      if (hit) q <= wr_data_i;
    end
    assign ent[g] = q;
  end

  assign rd_data_o = ent[rd_idx_i];
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter  int DEPTH = 4,
  parameter  int PC_W  = 10,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic            irq_i,
  input  logic            ret_i,
  input  logic [PC_W-1:0] cur_pc_i,
  output logic [PC_W-1:0] ret_pc_o,
  output logic            full_o,
  output logic            irq_ack_o,
  output logic            udf_o
);
  logic [1:0]    rst_sync_q;
  logic          core_rst_n;
  logic          push, wr_en;
  logic [PW-1:0] wr_idx, rd_idx;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  rs_irq_gate u_gate (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .irq_i  (irq_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .full_i (full_o),
    .ack_o  (irq_ack_o)
  );

  assign push = call_i | irq_ack_o;

  rs_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .push_i   (push),
    .pop_i    (ret_i),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .rd_idx_o (rd_idx),
    .full_o   (full_o),
    .udf_o    (udf_o)
  );

  rs_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (cur_pc_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (ret_pc_o)
  );
endmodule

// File: rtl/rs_checker.sv
module rs_checker (
  input logic clk,
  input logic rst_n,
  input logic call_i,
  input logic irq_i,
  input logic ret_i,
  input logic full_o,
  input logic irq_ack_o,
  input logic udf_o
);
  assert_no_ack_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !irq_ack_o);

  assert_call_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> (!call_i && !ret_i));

  assert_deferred_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && ret_i && !call_i && irq_i) |=> (call_i || ret_i || irq_ack_o));

  assert_overflow_keeps_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && call_i && !ret_i) |=> full_o);

  assert_udf_only_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    udf_o |-> (ret_i && !full_o));

  assert_single_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |=> (!irq_ack_o || irq_i));
endmodule

bind ret_stack rs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .call_i    (call_i),
  .irq_i     (irq_i),
  .ret_i     (ret_i),
  .full_o    (full_o),
  .irq_ack_o (irq_ack_o),
  .udf_o     (udf_o)
);

// File: tb/ret_stack_bench.sv
`timescale 1ns/1ps
module ret_stack_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       call_i, irq_i, ret_i;
  logic [9:0] cur_pc_i;
  logic [9:0] ret_pc_o;
  logic       full_o, irq_ack_o, udf_o;

  int vectors = 0;
  int errs    = 0;
  bit done    = 1'b0;

  // reference: index 0 is the oldest entry
  logic [9:0] m_stk [4];
  int         m_n;
  bit         m_pend;

  always #2 clk = ~clk;

  ret_stack u_ret_stack (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .irq_i(irq_i), .ret_i(ret_i),
    .cur_pc_i(cur_pc_i), .ret_pc_o(ret_pc_o), .full_o(full_o),
    .irq_ack_o(irq_ack_o), .udf_o(udf_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; call_i = 0; irq_i = 0; ret_i = 0; cur_pc_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_n = 0; m_pend = 0;
    // R1: empty, not full, no grant
    chk(full_o == 1'b0, "R1 full after reset", full_o, 0);
    chk(irq_ack_o == 1'b0, "R1 grant after reset", irq_ack_o, 0);
  endtask

  task automatic step(input bit c, input bit i, input bit r, input logic [9:0] pc,
                      input string ctx);
    bit eack, eudf, push;
    @(negedge clk);
    call_i = c; irq_i = i; ret_i = r; cur_pc_i = pc;
    #1;
    eack = (m_pend | i) && (m_n < 4) && !c && !r;   // R4 R6 R9
    eudf = r && (m_n == 0);                          // R10
    chk(irq_ack_o == eack, {"R4 grant ", ctx}, irq_ack_o, eack);
    chk(full_o == (m_n == 4), {"R5 full ", ctx}, full_o, (m_n == 4));
    chk(udf_o == eudf, {"R10 underflow ", ctx}, udf_o, eudf);
    if (r && m_n > 0)
      chk(ret_pc_o == m_stk[m_n-1], {"R3 popped address ", ctx}, ret_pc_o, m_stk[m_n-1]);
    push = c | eack;
    if (r && push && m_n > 0) begin
      m_stk[m_n-1] = pc;                       // R11 replace newest
    end else begin
      if (r && m_n > 0) m_n--;
      if (push) begin
        if (m_n < 4) begin
          m_stk[m_n] = pc; m_n++;
        end else begin                         // R8 drop oldest
          for (int k = 0; k < 3; k++) m_stk[k] = m_stk[k+1];
          m_stk[3] = pc;
        end
      end
    end
    m_pend = (m_pend | i) & ~eack;             // R12
  endtask

  task automatic idle(input string ctx);
    step(0, 0, 0, 10'h000, ctx);
  endtask

  initial begin
    rst_n = 1'b0; call_i = 0; irq_i = 0; ret_i = 0; cur_pc_i = '0;
    m_n = 0; m_pend = 0;
    do_reset();
    // R1: first return on an empty stack underflows
    step(0, 0, 1, 10'h000, "R1 empty return");

    // R2 R3: LIFO order
    step(1, 0, 0, 10'h101, "R2 call");
    step(1, 0, 0, 10'h202, "R2 call");
    step(0, 0, 1, 10'h000, "R3 return");
    step(0, 0, 1, 10'h000, "R3 return");

    // R8: five calls drop the first address; five returns then underflow
    for (int k = 0; k < 5; k++) step(1, 0, 0, 10'(10'h300 + k), "R8 fill");
    for (int k = 0; k < 5; k++) step(0, 0, 1, 10'h000, "R8 drain");

    // R6 R7: deferred grant on a full stack
    for (int k = 0; k < 4; k++) step(1, 0, 0, 10'(10'h040 + k), "R6 fill");
    step(0, 1, 0, 10'h3aa, "R6 request while full");
    idle("R6 still full");
    step(0, 0, 1, 10'h000, "R7 free a level");
    step(0, 0, 0, 10'h3bb, "R7 deferred grant");
    idle("R12 no second grant");
    for (int k = 0; k < 4; k++) step(0, 0, 1, 10'h000, "R7 drain");

    // R9 R11: same-cycle collisions
    step(1, 1, 0, 10'h0c1, "R9 call with request");
    idle("R9 later grant");
    step(1, 0, 1, 10'h0c3, "R11 return with call");
    step(0, 0, 1, 10'h000, "R11 check replaced");
    step(0, 0, 1, 10'h000, "R11 check below");
    step(1, 0, 1, 10'h0c4, "R10 return with call when empty");
    step(0, 0, 1, 10'h000, "R10 call was saved");

    // sweep: every occupancy, latched request or not, every input combination
    for (int occ = 0; occ <= 4; occ++)
      for (int pd = 0; pd < 2; pd++)
        for (int cmb = 0; cmb < 8; cmb++) begin
          do_reset();
          for (int k = 0; k < occ; k++)
            step(1, (pd == 1 && k == occ - 1), 0, 10'(occ * 64 + k), "sweep fill");
          if (pd == 1 && occ == 0) step(1, 1, 0, 10'h155, "sweep latch");
          step(cmb[0], cmb[1], cmb[2], 10'(10'h200 + cmb), "R9 R11 sweep collision");
          idle("R7 sweep follow");
          for (int k = 0; k < 6; k++) step(0, 0, 1, 10'h000, "R3 sweep drain");
        end

    // pseudo-random run against the model
    begin
      logic [15:0] lf = 16'hace1;
      do_reset();
      for (int n = 0; n < 3000; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(lf[2:0] < 3'd3, lf[6:5] == 2'd0, lf[4:3] == 2'd0, lf[15:6], "R2 R4 mixed");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errs++;
      $display("FAIL watchdog: act=%0h exp=%0h", 0, 1);
      summary();
      $finish;
    end
  end
endmodule